// File: doc/BRIEF.md
# SD Host Command Issue Controller

This block is the command side of a simplified SD host controller register file. Software writes a block-count argument, a command argument and then the command word. The block decides whether the command may be issued. If it may, it hands the command to a card-side request port and holds a command-busy flag until the card answers. The answer is a response flag, optional response data, or a timeout. From it the block updates the response words and the normal and error status, and it drives one interrupt line. The block has no data path, no DMA and no power control.

The issue decision follows a few rules. No power-enable bit is needed. The SD clock enable must be on. A command that uses the data line, or that expects a busy-signalling response, waits while the data path reports inhibit or a stop is pending. A response that the card returns to a command that asked for none is thrown away, and the command still completes normally. Card-inserted status is present after power-on. A software reset-all removes it for good, and it never raises the interrupt.

Top module: `sdcmd_ctrl`

## Requirements
- R1: After power-on reset every register reads zero, with two exceptions: status bit 6 (card inserted, word 0x30) and present-state bit 16 (word 0x24) read one. `irq` and `card_req` are low.
- R2: A write to word 0x0C is accepted when the SD clock enable (word 0x2C bit 2) is set and no command is busy. In the cycle after the write, `card_req` is high for exactly one cycle, with `card_idx` = bits 29:24, `card_arg` = word 0x08 and `card_blk_arg` = word 0x00. Present-state bit 0 stays set until the card answers.
- R3: While the SD clock enable is clear, a write to word 0x0C is dropped: no request, and the command word is unchanged.
- R4: While `dat_inhibit` or `stop_pending` is high, a command is refused if it has bit 21 set (uses data) or response type (bits 17:16) equal to 3 (busy). Other commands are issued.
- R5: A command write while present-state bit 0 is set is dropped and leaves the command word unchanged.
- R6: On a non-timeout answer that carries data, the response words are written according to the response type. Type 1 writes words 0x10..0x1C from data bits 31:0..127:96. Types 2 and 3 write word 0x10 only. Type 0 writes nothing and raises no error.
- R7: A completed command sets status bit 0 only if enable bit 0 (word 0x34) is set. A type-3 command also sets status bit 1 if enable bit 1 is set.
- R8: A timeout answer sets error bit 16 of word 0x30 if enable bit 16 is set. Status bit 15 reads one whenever any of bits 31:16 is set.
- R9: Writing ones to word 0x30 clears the matching bits 14:0 and 31:16.
- R10: `irq` is high exactly when some status bit other than bit 6 is set and the matching signal-enable bit (word 0x38) is also set. Card-inserted status never drives `irq`.
- R11: Writing word 0x2C with bit 24 set clears all registers, the busy flag and both card-inserted bits. Both card-inserted bits stay clear afterwards, and commands can be issued again.
- R12: Word 0x00 holds a 32-bit block-count argument that reads back as written and appears on `card_blk_arg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the written word |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read word |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| dat_inhibit | input | 1 | Data path busy |
| stop_pending | input | 1 | Stop of a data transfer still pending |
| card_req | output | 1 | One-cycle command request to the card |
| card_idx | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| card_blk_arg | output | 32 | Block-count argument |
| card_rsp_valid | input | 1 | Card answer strobe |
| card_rsp_has | input | 1 | Answer carries response data |
| card_rsp_timeout | input | 1 | Card did not answer |
| card_rsp_data | input | 128 | Response bits |

## Verification
The hardest state to reach is one where card-inserted status is still set from power-on while its signal-enable bit is on. Here an interrupt would appear if that bit were wired into the interrupt term. The stimulus arms the signal enable before any command and checks that `irq` stays low. A second hard case is the answer carrying data for a type-0 command. The bench first fills response word 0 with a known value, then issues a type-0 command and answers it with different data, and checks that the word keeps its old value and that no error bit appears. The permanent loss of card-inserted status is reached with a reset-all write, followed by a full command sequence that must not bring the bit back.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    // Register map, byte addresses of 32-bit words
    localparam int          REG_AW   = 8;
    localparam logic [7:0]  A_BLKARG = 8'h00;
    localparam logic [7:0]  A_ARG    = 8'h08;
    localparam logic [7:0]  A_CMD    = 8'h0C;
    localparam logic [7:0]  A_RSP0   = 8'h10;
    localparam logic [7:0]  A_PRES   = 8'h24;
    localparam logic [7:0]  A_CLK    = 8'h2C;
    localparam logic [7:0]  A_STS    = 8'h30;
    localparam logic [7:0]  A_STSEN  = 8'h34;
    localparam logic [7:0]  A_SIGEN  = 8'h38;

    // Bit positions software decodes
    localparam int B_CLK_ON   = 2;
    localparam int B_RST_ALL  = 24;
    localparam int B_DATA     = 21;
    localparam int B_IDX_LO   = 24;
    localparam int B_CARD_INS = 6;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_136  = 2'd1,
        RSP_48   = 2'd2,
        RSP_48B  = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/sdcmd_gate.sv
// Issue gate: decides whether a freshly written command may go to the card.
// Assumes the caller presents the new command word in the same cycle.
module sdcmd_gate (
    input  logic                  clk_on,
    input  logic                  cmd_busy,
    input  logic                  dat_inh,
    input  logic                  stop_pend,
    input  logic                  wants_data,
    input  sdcmd_pkg::rsp_kind_e  kind,
    output logic                  permit
);
    import sdcmd_pkg::*;

    logic line_user;

    // Combine clock, busy and data-line conditions into one permit
    always_comb begin
        line_user = wants_data | (kind == RSP_48B);
        permit    = clk_on & ~cmd_busy & ~((dat_inh | stop_pend) & line_user);
    end
endmodule

// File: rtl/sdcmd_status.sv
// Status, status-enable and signal-enable registers plus interrupt line.
// Assumes set strobes are single-cycle and already qualified by the caller.
module sdcmd_status #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  wr_sts,
    input  logic                  wr_en,
    input  logic                  wr_sig,
    input  logic [2*HALF_W-1:0]   wdata,
    input  logic                  set_done,
    input  logic                  set_xfer,
    input  logic                  set_tmo,
    output logic [2*HALF_W-1:0]   sts_word,
    output logic [2*HALF_W-1:0]   en_word,
    output logic                  ins_flag,
    output logic                  irq
);
    import sdcmd_pkg::*;

    localparam int W = 2 * HALF_W;

    logic [HALF_W-1:0] nrm_q, err_q, nrm_set, err_set, nrm_clr, err_clr;
    logic [W-1:0]      en_q, sig_q;
    logic              ins_q;
    logic [HALF_W-1:0] ins_mask;

    // Set vectors gated by status enable, clear vectors from write-one
    always_comb begin
        nrm_set    = '0;
        err_set    = '0;
        nrm_set[0] = set_done & en_q[0];
        nrm_set[1] = set_xfer & en_q[1];
        err_set[0] = set_tmo & en_q[HALF_W];
        nrm_clr    = wr_sts ? wdata[HALF_W-1:0] : '0;
        err_clr    = wr_sts ? wdata[W-1:HALF_W] : '0;
    end

    // Status and enable storage; power-on sets card-inserted only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrm_q             <= '0;
            nrm_q[B_CARD_INS] <= 1'b1;
            err_q             <= '0;
            en_q              <= '0;
            sig_q             <= '0;
            ins_q             <= 1'b1;
        end else if (soft_rst) begin
            nrm_q <= '0;
            err_q <= '0;
            en_q  <= '0;
            sig_q <= '0;
            ins_q <= 1'b0;
        end else begin
            nrm_q <= ((nrm_q & ~nrm_clr) | nrm_set) & ~(HALF_W'(1) << (HALF_W-1));
            err_q <= (err_q & ~err_clr) | err_set;
            if (wr_en)  en_q  <= wdata;
            if (wr_sig) sig_q <= wdata;
        end
    end

    // Visible word with error summary, interrupt excluding card-inserted
    always_comb begin
        sts_word = {err_q, |err_q, nrm_q[HALF_W-2:0]};
        en_word  = en_q;
        ins_flag = ins_q;
        ins_mask = ~(HALF_W'(1) << B_CARD_INS);
        irq      = (|(sts_word[HALF_W-1:0] & sig_q[HALF_W-1:0] & ins_mask)) |
                   (|(err_q & sig_q[W-1:HALF_W]));
    end

    p_ins_never_rises_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(nrm_q[B_CARD_INS]));
    p_xfer_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrm_q[1]) |-> $past(set_xfer));
    p_tmo_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[0]) |-> $past(set_tmo));
endmodule

// File: rtl/sdcmd_ctrl.sv
// Command-issue controller top: argument, command, response and clock
// registers, issue decision, card request port and register read mux.
// Assumes one register write per cycle and at most one command in flight.
module sdcmd_ctrl #(
    parameter int DW    = 32,
    parameter int IDX_W = 6,
    parameter int RSP_N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    input  logic [7:0]           rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic                 irq,
    input  logic                 dat_inhibit,
    input  logic                 stop_pending,
    output logic                 card_req,
    output logic [IDX_W-1:0]     card_idx,
    output logic [DW-1:0]        card_arg,
    output logic [DW-1:0]        card_blk_arg,
    input  logic                 card_rsp_valid,
    input  logic                 card_rsp_has,
    input  logic                 card_rsp_timeout,
    input  logic [RSP_N*DW-1:0]  card_rsp_data
);
    import sdcmd_pkg::*;

    localparam int CLK_W = DW / 2;

    logic [DW-1:0]    blk_q, arg_q, cmd_q;
    logic [DW-1:0]    rsp_q [RSP_N];
    logic [CLK_W-1:0] clk_q;
    logic             inh_q, req_q;
    logic             soft_rst, wr_cmd, permit, accept, cmd_ok;
    rsp_kind_e        cur_kind, new_kind;
    logic [DW-1:0]    sts_word, en_word;
    logic             ins_flag;

    // Decode write strobes and the card answer qualification
    always_comb begin
        soft_rst = reg_wr && reg_addr == A_CLK && reg_wdata[B_RST_ALL];
        wr_cmd   = reg_wr && reg_addr == A_CMD;
        cur_kind = rsp_kind_e'(cmd_q[17:16]);
        new_kind = rsp_kind_e'(reg_wdata[17:16]);
        accept   = card_rsp_valid && inh_q && !soft_rst;
        cmd_ok   = accept && !card_rsp_timeout;
    end

    sdcmd_gate u_gate (
        .clk_on     (clk_q[B_CLK_ON]),
        .cmd_busy   (inh_q),
        .dat_inh    (dat_inhibit),
        .stop_pend  (stop_pending),
        .wants_data (reg_wdata[B_DATA]),
        .kind       (new_kind),
        .permit     (permit)
    );

    sdcmd_status #(.HALF_W(DW/2)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_sts   (reg_wr && reg_addr == A_STS),
        .wr_en    (reg_wr && reg_addr == A_STSEN),
        .wr_sig   (reg_wr && reg_addr == A_SIGEN),
        .wdata    (reg_wdata),
        .set_done (cmd_ok),
        .set_xfer (cmd_ok && cur_kind == RSP_48B),
        .set_tmo  (accept && card_rsp_timeout),
        .sts_word (sts_word),
        .en_word  (en_word),
        .ins_flag (ins_flag),
        .irq      (irq)
    );

    // Argument, command, clock, busy flag and request pulse
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            blk_q <= '0;
            arg_q <= '0;
            cmd_q <= '0;
            clk_q <= '0;
            inh_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (accept) inh_q <= 1'b0;
            if (reg_wr && reg_addr == A_BLKARG) blk_q <= reg_wdata;
            if (reg_wr && reg_addr == A_ARG)    arg_q <= reg_wdata;
            if (reg_wr && reg_addr == A_CLK)    clk_q <= reg_wdata[CLK_W-1:0];
            if (wr_cmd && permit) begin
                cmd_q <= reg_wdata;
                inh_q <= 1'b1;
                req_q <= 1'b1;
            end
        end
    end

    // Response words: long type fills all, short types fill the first only
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int i = 0; i < RSP_N; i++) rsp_q[i] <= '0;
        end else if (cmd_ok && card_rsp_has && cur_kind != RSP_NONE) begin
            for (int i = 0; i < RSP_N; i++) begin
                if (cur_kind == RSP_136 || i == 0) rsp_q[i] <= card_rsp_data[i*DW +: DW];
            end
        end
    end

    // Card request outputs
    always_comb begin
        card_req     = req_q;
        card_idx     = cmd_q[B_IDX_LO +: IDX_W];
        card_arg     = arg_q;
        card_blk_arg = blk_q;
    end

    // Register read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_BLKARG: rd_data = blk_q;
            A_ARG:    rd_data = arg_q;
            A_CMD:    rd_data = cmd_q;
            A_PRES: begin
                rd_data[0]  = inh_q;
                rd_data[1]  = dat_inhibit;
                rd_data[16] = ins_flag;
            end
            A_CLK:    rd_data = DW'(clk_q);
            A_STS:    rd_data = sts_word;
            A_STSEN:  rd_data = en_word;
            default: begin
                for (int i = 0; i < RSP_N; i++) begin
                    if (rd_addr == A_RSP0 + 8'(4 * i)) rd_data = rsp_q[i];
                end
            end
        endcase
    end

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |=> !card_req);
    p_req_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> $past(clk_q[B_CLK_ON]));
    p_one_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> $past(!inh_q));
    p_line_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> ($past(!(dat_inhibit || stop_pending)) ||
                      !(cmd_q[B_DATA] || cmd_q[17:16] == 2'd3)));
    p_unasked_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cur_kind == RSP_NONE) |=> $stable(rsp_q[0]));
endmodule

// File: tb/tb_sdcmd_ctrl.sv
module tb_sdcmd_ctrl;
    localparam int P = 10;

    logic         clk = 0, rst_n = 0;
    logic         reg_wr = 0;
    logic [7:0]   reg_addr = 0, rd_addr = 0;
    logic [31:0]  reg_wdata = 0, rd_data;
    logic         irq, dat_inhibit = 0, stop_pending = 0;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg, card_blk_arg;
    logic         card_rsp_valid = 0, card_rsp_has = 0, card_rsp_timeout = 0;
    logic [127:0] card_rsp_data = 0;

    int    n_chk = 0, n_err = 0;
    string cur_tag = "R1";
    bit    running = 0;

    always #(P/2) clk = ~clk;

    sdcmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
        .dat_inhibit(dat_inhibit), .stop_pending(stop_pending),
        .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
        .card_blk_arg(card_blk_arg), .card_rsp_valid(card_rsp_valid),
        .card_rsp_has(card_rsp_has), .card_rsp_timeout(card_rsp_timeout),
        .card_rsp_data(card_rsp_data)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_blk, m_arg, m_cmd, m_en, m_sig;
    logic [31:0] m_rsp [4];
    logic [15:0] m_clk, m_nrm, m_err;
    bit          m_inh, m_pres, m_req, m_ok, m_line;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_blk;
            8'h08: return m_arg;
            8'h0C: return m_cmd;
            8'h10: return m_rsp[0];
            8'h14: return m_rsp[1];
            8'h18: return m_rsp[2];
            8'h1C: return m_rsp[3];
            8'h24: return {15'd0, m_pres, 14'd0, dat_inhibit, m_inh};
            8'h2C: return {16'd0, m_clk};
            8'h30: return {m_err, |m_err, m_nrm[14:0]};
            8'h34: return m_en;
            8'h38: return 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        logic [31:0] s;
        s = m_read(8'h30);
        return (|(s[15:0] & m_sig[15:0] & 16'hFFBF)) | (|(m_err & m_sig[31:16]));
    endfunction

    task automatic m_zero();
        m_blk = 0; m_arg = 0; m_cmd = 0; m_en = 0; m_sig = 0; m_clk = 0;
        m_nrm = 0; m_err = 0; m_inh = 0; m_req = 0;
        for (int i = 0; i < 4; i++) m_rsp[i] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_zero();
            m_nrm = 16'h0040;
            m_pres = 1;
        end else begin
            m_req  = 0;
            m_line = reg_wdata[21] || reg_wdata[17:16] == 2'd3;
            m_ok   = m_clk[2] && !m_inh && !((dat_inhibit || stop_pending) && m_line);
            if (reg_wr && reg_addr == 8'h30) begin
                m_nrm = m_nrm & ~reg_wdata[15:0];
                m_nrm[15] = 0;
                m_err = m_err & ~reg_wdata[31:16];
            end
            if (card_rsp_valid && m_inh) begin
                m_inh = 0;
                if (card_rsp_timeout) begin
                    if (m_en[16]) m_err[0] = 1;
                end else begin
                    if (m_en[0]) m_nrm[0] = 1;
                    if (m_cmd[17:16] == 2'd3 && m_en[1]) m_nrm[1] = 1;
                    if (card_rsp_has) begin
                        if (m_cmd[17:16] == 2'd1)
                            for (int i = 0; i < 4; i++) m_rsp[i] = card_rsp_data[32*i +: 32];
                        else if (m_cmd[17:16] != 2'd0)
                            m_rsp[0] = card_rsp_data[31:0];
                    end
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    8'h00: m_blk = reg_wdata;
                    8'h08: m_arg = reg_wdata;
                    8'h0C: if (m_ok) begin m_cmd = reg_wdata; m_inh = 1; m_req = 1; end
                    8'h2C: m_clk = reg_wdata[15:0];
                    8'h34: m_en = reg_wdata;
                    8'h38: m_sig = reg_wdata;
                    default: ;
                endcase
                if (reg_addr == 8'h2C && reg_wdata[24]) begin
                    m_zero();
                    m_pres = 0;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, a quarter period after the edge
    always @(posedge clk) begin
        #(P/4);
        if (running) begin
            check("R10", {31'd0, irq}, {31'd0, m_irq()});
            check("R2", {31'd0, card_req}, {31'd0, m_req});
            check(cur_tag, rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic answer(input bit has, input bit tmo, input logic [127:0] d);
        @(negedge clk);
        card_rsp_valid = 1; card_rsp_has = has; card_rsp_timeout = tmo; card_rsp_data = d;
        @(negedge clk);
        card_rsp_valid = 0; card_rsp_has = 0; card_rsp_timeout = 0;
    endtask

    localparam logic [127:0] D1 = 128'h44444444_33333333_22222222_11111111;
    localparam logic [127:0] D2 = {4{32'hAAAAAAAA}};

    initial begin
        #(P * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        // R1 reset state
        rd("R1", 8'h30, 32'h0000_0040);
        rd("R1", 8'h24, 32'h0001_0000);
        check("R1", {31'd0, irq}, 32'd0);
        check("R1", {31'd0, card_req}, 32'd0);
        // R12 block-count argument
        cur_tag = "R12";
        wr(8'h00, 32'h0000_0007);
        rd("R12", 8'h00, 32'h0000_0007);
        check("R12", card_blk_arg, 32'h0000_0007);
        wr(8'h08, 32'hA5A5_0001);
        // R3 clock disabled
        cur_tag = "R3";
        wr(8'h0C, 32'h1102_0000);
        check("R3", {31'd0, card_req}, 32'd0);
        rd("R3", 8'h0C, 32'd0);
        // R10 card-inserted never interrupts
        cur_tag = "R10";
        wr(8'h2C, 32'h0000_0004);
        wr(8'h34, 32'h0001_0003);
        wr(8'h38, 32'h0001_0043);
        check("R10", {31'd0, irq}, 32'd0);
        // R2 issue
        cur_tag = "R2";
        wr(8'h0C, 32'h1102_0000);
        check("R2", {31'd0, card_req}, 32'd1);
        check("R2", {26'd0, card_idx}, 32'd17);
        check("R2", card_arg, 32'hA5A5_0001);
        rd("R2", 8'h24, 32'h0001_0001);
        @(negedge clk);
        check("R2", {31'd0, card_req}, 32'd0);
        // R5 busy refuses
        cur_tag = "R5";
        wr(8'h0C, 32'h0502_0000);
        check("R5", {31'd0, card_req}, 32'd0);
        rd("R5", 8'h0C, 32'h1102_0000);
        // R6 short response
        cur_tag = "R6";
        answer(1, 0, D1);
        rd("R6", 8'h10, 32'h1111_1111);
        rd("R6", 8'h14, 32'd0);
        rd("R7", 8'h30, 32'h0000_0041);
        check("R10", {31'd0, irq}, 32'd1);
        // R9 clear
        cur_tag = "R9";
        wr(8'h30, 32'h0000_0001);
        rd("R9", 8'h30, 32'h0000_0040);
        check("R10", {31'd0, irq}, 32'd0);
        // R6 long response
        cur_tag = "R6";
        wr(8'h0C, 32'h0201_0000);
        answer(1, 0, D1);
        rd("R6", 8'h1C, 32'h4444_4444);
        rd("R6", 8'h18, 32'h3333_3333);
        wr(8'h30, 32'h0000_0001);
        // R6 unrequested response dropped, no error
        wr(8'h0C, 32'h1700_0000);
        answer(1, 0, D2);
        rd("R6", 8'h10, 32'h1111_1111);
        rd("R6", 8'h30, 32'h0000_0041);
        wr(8'h30, 32'h0000_0001);
        // R7 busy type sets transfer complete
        cur_tag = "R7";
        wr(8'h0C, 32'h0C03_0000);
        answer(1, 0, D1);
        rd("R7", 8'h30, 32'h0000_0043);
        wr(8'h30, 32'h0000_0003);
        // R4 data inhibit and stop pending
        cur_tag = "R4";
        dat_inhibit = 1;
        wr(8'h0C, 32'h0C03_0000);
        check("R4", {31'd0, card_req}, 32'd0);
        wr(8'h0C, 32'h1122_0000);
        check("R4", {31'd0, card_req}, 32'd0);
        wr(8'h0C, 32'h0D02_0000);
        check("R4", {31'd0, card_req}, 32'd1);
        answer(0, 0, D1);
        wr(8'h30, 32'h0000_0001);
        dat_inhibit = 0;
        stop_pending = 1;
        wr(8'h0C, 32'h0C03_0000);
        check("R4", {31'd0, card_req}, 32'd0);
        stop_pending = 0;
        // R8 timeout
        cur_tag = "R8";
        wr(8'h0C, 32'h0802_0000);
        answer(0, 1, D1);
        rd("R8", 8'h30, 32'h0001_8040);
        check("R8", {31'd0, irq}, 32'd1);
        wr(8'h30, 32'h0001_0000);
        rd("R9", 8'h30, 32'h0000_0040);
        // R7 status enable gating
        cur_tag = "R7";
        wr(8'h34, 32'd0);
        wr(8'h0C, 32'h0D02_0000);
        answer(1, 0, D1);
        rd("R7", 8'h30, 32'h0000_0040);
        // R11 reset-all
        cur_tag = "R11";
        wr(8'h2C, 32'h0100_0000);
        rd("R11", 8'h30, 32'd0);
        rd("R11", 8'h24, 32'd0);
        rd("R11", 8'h2C, 32'd0);
        rd("R11", 8'h00, 32'd0);
        wr(8'h2C, 32'h0000_0004);
        wr(8'h34, 32'h0000_0001);
        wr(8'h0C, 32'h0D02_0000);
        check("R11", {31'd0, card_req}, 32'd1);
        answer(1, 0, D1);
        rd("R11", 8'h30, 32'h0000_0001);
        rd("R11", 8'h24, 32'd0);
        repeat (3) @(negedge clk);
        running = 0;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule